// File: doc/BRIEF.md
# Two-Level Alarm Annunciator

This block is a clocked annunciator controller for process monitoring. It takes two alarm lines, a low-level alarm and a high-level alarm, and an operator acknowledge. From these it drives two lamps. An amber lamp flashes for a first-level hazard. A red lamp flashes for an emergency. When the operator acknowledges, the flashing lamp goes steady. The high-level alarm counts only while the low-level alarm is present, so a high alarm on its own never raises the state. The controller goes back to normal only after the alarm has cleared and the operator has acknowledged it.

All inputs are sampled on the rising clock edge. Every transition is a synchronous event of a 3-bit state register with a fixed binary code, and that code is also visible on a port. Six codes are used and the two spare codes return to normal on the next clock. A parameterised divider makes a flash enable with a 50% duty cycle that all flashing lamps share. There is no data stream at the edge, so every pin is a plain level signal with no valid/ready handshake and no back-pressure.

Top module: `alarm_annunciator`

## Requirements
- R1: A synchronous reset puts the state in normal (code 000) and clears the flash divider, so both lamps are off after reset.
- R2: In normal (000), a set low alarm moves the state to amber-flashing (001). With the low alarm clear, the state stays 000 whatever the high alarm and acknowledge do.
- R3: Acknowledge with the low alarm still set moves amber-flashing (001) to amber-steady (010). It moves red-flashing (011) to red-steady (100) if the high alarm is set, or to amber-steady (010) if it is clear. Without acknowledge a flashing state holds.
- R4: With both alarms set, amber-flashing (001) and amber-steady (010) move to red-flashing (011).
- R5: The state returns to 000 only when the low alarm is clear and the alarm has been acknowledged. Steady states (010, 100) do this as soon as the low alarm clears. Flashing states (001, 011) do it when the low alarm is clear and acknowledge is set in the same cycle.
- R6: If the low alarm clears in 001 or 011 without acknowledge, the state goes to cleared-unacknowledged (101). In 101, a low alarm goes back to 001. Otherwise acknowledge goes to 000, and with neither the state holds.
- R7: In red-steady (100), clearing the high alarm while the low alarm stays set falls back to amber-steady (010).
- R8: The spare codes 110 and 111 go to 000 on the next clock.
- R9: The flash enable is on for FLASH_HALF cycles and then off for FLASH_HALF cycles, starting on at the first cycle after reset. After k clocks out of reset it equals ((k / FLASH_HALF) mod 2) == 0.
- R10: Lamp outputs by state: 000 and the spare codes light neither lamp. 001 and 101 give amber equal to the flash enable. 010 gives amber fully on. 011 gives red equal to the flash enable. 100 gives red fully on. Amber and red are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| low_alarm | input | 1 | First-level fault input |
| high_alarm | input | 1 | Emergency input, meaningful only with low_alarm set |
| ack | input | 1 | Operator acknowledge |
| amber_lamp | output | 1 | Amber lamp drive |
| red_lamp | output | 1 | Red lamp drive |
| state_code | output | 3 | Current state code |

## Verification
The bench brings the design to each of the six proper states and applies all eight combinations of the two alarms and acknowledge. After each one it compares the next state and both lamps with a model written from the requirements. This sweep targets three likely mistakes. A design that lets a lone high alarm escalate from normal would go to 011 or 001 instead of holding 000. A design that drops to normal when the alarm clears without acknowledge would skip 101. A design that ignores the high alarm when acknowledging red would land in 100 when it should land in 010. The spare codes are loaded into the state register, and a design without recovery would stay stuck in them. A long hold in a flashing state checks the flash phase each cycle, which catches an off-by-one in the divider period or a wrong starting polarity.

// File: rtl/ann_pkg.sv
package ann_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL  = 3'b000,
    ST_AMB_FL  = 3'b001,
    ST_AMB_ON  = 3'b010,
    ST_RED_FL  = 3'b011,
    ST_RED_ON  = 3'b100,
    ST_CLR_FL  = 3'b101,
    ST_SPARE6  = 3'b110,
    ST_SPARE7  = 3'b111
  } ann_state_e;

  localparam int STATE_W = 3;
endpackage

// File: rtl/ann_flash_div.sv
module ann_flash_div #(
  parameter int FLASH_HALF = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic flash_on
);
  localparam int CW = (FLASH_HALF > 1) ? $clog2(FLASH_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(FLASH_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          flash_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      flash_q <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      flash_q <= ~flash_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign flash_on = flash_q;

  // R9: the phase changes only at the end of a half period
  p_flash_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != LAST) |=> $stable(flash_q));
  p_flash_flip_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST) |=> (flash_q != $past(flash_q)));
  p_cnt_range_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/ann_fsm.sv
module ann_fsm
  import ann_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               low_alarm,
  input  logic               high_alarm,
  input  logic               ack,
  output logic [STATE_W-1:0] state
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;
  logic               both_set;

  assign both_set = low_alarm & high_alarm;

  always_comb begin
    state_d = state_q;
    case (ann_state_e'(state_q))
      ST_NORMAL: begin
        if (low_alarm) state_d = ST_AMB_FL;
      end
      ST_AMB_FL: begin
        if (both_set)        state_d = ST_RED_FL;
        else if (!low_alarm) state_d = ack ? ST_NORMAL : ST_CLR_FL;
        else if (ack)        state_d = ST_AMB_ON;
      end
      ST_AMB_ON: begin
        if (both_set)        state_d = ST_RED_FL;
        else if (!low_alarm) state_d = ST_NORMAL;
      end
      ST_RED_FL: begin
        if (!low_alarm)      state_d = ack ? ST_NORMAL : ST_CLR_FL;
        else if (ack)        state_d = high_alarm ? ST_RED_ON : ST_AMB_ON;
      end
      ST_RED_ON: begin
        if (!low_alarm)       state_d = ST_NORMAL;
        else if (!high_alarm) state_d = ST_AMB_ON;
      end
      ST_CLR_FL: begin
        if (low_alarm)  state_d = ST_AMB_FL;
        else if (ack)   state_d = ST_NORMAL;
      end
      default: state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_NORMAL;
    else     state_q <= state_d;
  end

  assign state = state_q;

  // R2: a lone high alarm cannot leave normal
  p_hla_alone_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NORMAL && !low_alarm) |=> state_q == ST_NORMAL);
  // R4: escalation from either amber state
  p_escalate_r4: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_AMB_FL || state_q == ST_AMB_ON) && both_set) |=> state_q == ST_RED_FL);
  // R5: steady amber returns to normal once cleared
  p_return_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_AMB_ON && !low_alarm) |=> state_q == ST_NORMAL);
  // R6: unacknowledged clear parks in 101
  p_park_r6: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_AMB_FL || state_q == ST_RED_FL) && !low_alarm && !ack) |=> state_q == ST_CLR_FL);
  // R8: spare codes recover
  p_spare_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q[2:1] == 2'b11) |=> state_q == ST_NORMAL);
endmodule

// File: rtl/ann_lamp_drv.sv
module ann_lamp_drv
  import ann_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] state,
  input  logic               flash_on,
  output logic               amber,
  output logic               red
);
  always_comb begin
    amber = 1'b0;
    red   = 1'b0;
    case (ann_state_e'(state))
      ST_AMB_FL, ST_CLR_FL: amber = flash_on;
      ST_AMB_ON:            amber = 1'b1;
      ST_RED_FL:            red   = flash_on;
      ST_RED_ON:            red   = 1'b1;
      default: ;
    endcase
  end

  // R10: lamps are mutually exclusive; steady states fully lit
  p_lamp_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(amber && red));
  p_steady_amber_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AMB_ON) |-> amber);
  p_steady_red_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RED_ON) |-> red);
endmodule

// File: rtl/alarm_annunciator.sv
module alarm_annunciator #(
  parameter int FLASH_HALF = 25_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       low_alarm,
  input  logic       high_alarm,
  input  logic       ack,
  output logic       amber_lamp,
  output logic       red_lamp,
  output logic [2:0] state_code
);
  import ann_pkg::*;

  logic [STATE_W-1:0] cur_state;
  logic               flash_en;

  ann_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .low_alarm  (low_alarm),
    .high_alarm (high_alarm),
    .ack        (ack),
    .state      (cur_state)
  );

  ann_flash_div #(.FLASH_HALF(FLASH_HALF)) u_div (
    .clk      (clk),
    .rst      (rst),
    .flash_on (flash_en)
  );

  ann_lamp_drv u_lamp (
    .clk      (clk),
    .rst      (rst),
    .state    (cur_state),
    .flash_on (flash_en),
    .amber    (amber_lamp),
    .red      (red_lamp)
  );

  assign state_code = cur_state;
endmodule

// File: tb/alarm_annunciator_test.sv
`timescale 1ns/1ps
module alarm_annunciator_test;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lla = 1'b0, hla = 1'b0, ackn = 1'b0;
  logic amber, red;
  logic [2:0] code;
  int checks = 0;
  int errors = 0;
  int edges = 0;

  always #2.5 clk = ~clk;

  alarm_annunciator #(.FLASH_HALF(H)) uut (
    .clk(clk), .rst(rst), .low_alarm(lla), .high_alarm(hla), .ack(ackn),
    .amber_lamp(amber), .red_lamp(red), .state_code(code)
  );

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else     edges <= edges + 1;
  end

  function automatic int next_exp(int s, bit l, bit h, bit a);
    case (s)
      0: return l ? 1 : 0;
      1: if (l && h) return 3; else if (!l) return a ? 0 : 5; else if (a) return 2; else return 1;
      2: if (l && h) return 3; else if (!l) return 0; else return 2;
      3: if (!l) return a ? 0 : 5; else if (a) return h ? 4 : 2; else return 3;
      4: if (!l) return 0; else if (!h) return 2; else return 4;
      5: if (l) return 1; else if (a) return 0; else return 5;
      default: return 0;
    endcase
  endfunction

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_lamps(string req);
    int s = int'(code);
    bit fl = ((edges / H) % 2) == 0;
    int ea = (s == 1 || s == 5) ? int'(fl) : (s == 2 ? 1 : 0);
    int er = (s == 3) ? int'(fl) : (s == 4 ? 1 : 0);
    chk({30'd0, amber, red}, (ea << 1) | er, req);
  endtask

  task automatic step(bit l, bit h, bit a);
    lla = l; hla = h; ackn = a;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(0, 0, 0);
    step(0, 0, 0);
    rst = 1'b0;
  endtask

  task automatic go_to(int s);
    case (s)
      1: step(1, 0, 0);
      2: begin step(1, 0, 0); step(1, 0, 1); end
      3: begin step(1, 0, 0); step(1, 1, 0); end
      4: begin step(1, 0, 0); step(1, 1, 0); step(1, 1, 1); end
      5: begin step(1, 0, 0); step(0, 0, 0); end
      default: ;
    endcase
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: reset state and dark lamps
    chk(int'(code), 0, "R1 state");
    chk({30'd0, amber, red}, 0, "R1 lamps");

    // R2..R7, R10: full sweep of proper states and input combinations
    for (int s = 0; s < 6; s++) begin
      for (int c = 0; c < 8; c++) begin
        do_reset();
        go_to(s);
        chk(int'(code), s, "R11 reach");
        chk_lamps("R10 before");
        step(c[2], c[1], c[0]);
        chk(int'(code), next_exp(s, c[2], c[1], c[0]), "R2-sweep R3 R4 R5 R6 R7");
        chk_lamps("R10 after");
      end
    end

    // R8: spare codes recover to normal
    for (int sp = 6; sp < 8; sp++) begin
      do_reset();
      force uut.u_fsm.state_q = 3'(sp);
      #1;
      release uut.u_fsm.state_q;
      chk(int'(code), sp, "R8 loaded");
      chk({30'd0, amber, red}, 0, "R10 spare dark");
      step(0, 0, 0);
      chk(int'(code), 0, "R8 recover");
    end

    // R9: flash phase over several periods in amber-flashing
    do_reset();
    go_to(1);
    for (int k = 0; k < 5 * H; k++) begin
      chk(int'(amber), int'(((edges / H) % 2) == 0), "R9 amber phase");
      step(1, 0, 0);
    end
    // R9 in red-flashing
    do_reset();
    go_to(3);
    for (int k = 0; k < 3 * H; k++) begin
      chk(int'(red), int'(((edges / H) % 2) == 0), "R9 red phase");
      chk(int'(amber), 0, "R10 amber off in red");
      step(1, 1, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule